// File: doc/BRIEF.md
# Cascaded Two-Stage Clock Divider

This block turns a fast input clock into a slower clock. The division ratio is the product of two divisors held in one configuration word. The low field sets the first divisor M. The field above it sets the second divisor P. A static mode pin chooses how the P field is decoded:

- In exponent mode, P is a power of two.
- In linear mode, P is the field value plus an offset. This gives a contiguous range of divisors.

An enable pin starts and stops the output. A ratio of one passes the input clock straight through.

The configuration word is sampled again only when a full output period is complete, or while the divider is idle. Software can therefore rewrite it at any time without cutting a period short. Control pins are plain levels. No stream interface is involved, so there is no valid/ready handshake and no back-pressure.

Top module: `cascade_clkdiv`

## Requirements
- R1: The output period is N = Mdiv * Pdiv input cycles. With the defaults, N reaches 64 (M field 7 and P field 3 in exponent mode).
- R2: The M field is `cfg_word[2:0]` and Mdiv = field + 1. A field value of 0 divides by one.
- R3: With `lin_mode` = 0, the P field `cfg_word[4:3]` is an exponent. Pdiv = 2^field, so field values 0..3 give 1, 2, 4 and 8.
- R4: With `lin_mode` = 1, Pdiv = P field + 1, so field values 0..3 give 1 to 4.
- R5: For N >= 2, each period starts high for floor(N/2) input cycles and is low for the remaining cycles.
- R6: A new `cfg_word` or `lin_mode` value takes effect only when the current period ends. A change in mid-period leaves that period's length and shape unchanged.
- R7: When N = 1 and the block is enabled, `clk_out` follows `clk_in`.
- R8: When `en` is sampled low, the output is low from that edge on. Once `en` is sampled high, a new period begins at that edge, starting with its high phase.
- R9: During reset `clk_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 5 | Bits [4:3] hold the P field; bits [2:0] hold the M field |
| lin_mode | input | 1 | 0: P field is an exponent; 1: P field is a divisor minus 1 |
| en | input | 1 | Level enable for the output clock |
| clk_out | output | 1 | Divided clock |

## Verification
On every cycle, the assertions check the following:
- The position counter stays below the active ratio.
- The active ratio changes only at a period boundary.
- The output rises only at position zero and falls only at the half point.
- A deasserted enable empties the divider.

The checks that depend on the actual numeric decoding are shown only by the bench scenarios. These cover the two P encodings, the product with M, the pass-through at a ratio of one, and mid-period reconfiguration. In those scenarios, a behavioural model is sampled in both clock phases.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  typedef enum logic {
    PDEC_EXP = 1'b0,
    PDEC_LIN = 1'b1
  } pdec_e;
endpackage

// File: rtl/cdiv_ratio.sv
module cdiv_ratio
  import cdiv_pkg::*;
#(
  parameter int M_W   = 3,
  parameter int P_W   = 2,
  parameter int M_OFF = 1,
  parameter int P_OFF = 1,
  parameter int MD_W  = 4,
  parameter int PD_W  = 4,
  parameter int N_W   = 8
) (
  input  logic [M_W+P_W-1:0] cfg_word,
  input  logic               lin_mode,
  output logic [N_W-1:0]     ratio
);
  logic [MD_W-1:0] m_div;
  logic [PD_W-1:0] p_div;
  logic [P_W-1:0]  p_fld;
  logic [N_W-1:0]  prod;
  pdec_e           dec;

  always_comb begin
    dec   = pdec_e'(lin_mode);
    m_div = MD_W'(cfg_word[M_W-1:0]) + MD_W'(M_OFF);
    p_fld = cfg_word[M_W +: P_W];
    if (dec == PDEC_LIN) p_div = PD_W'(p_fld) + PD_W'(P_OFF);
    else                 p_div = PD_W'(1) << p_fld;
    prod  = N_W'(m_div) * N_W'(p_div);
    // a zero offset could yield zero: treat it as divide by one
    ratio = (prod == '0) ? N_W'(1) : prod;
  end
endmodule

// File: rtl/cdiv_phase.sv
module cdiv_phase #(
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [N_W-1:0] ratio,
  output logic           run,
  output logic           hi,
  output logic [N_W-1:0] cnt,
  output logic [N_W-1:0] cur_n
);
  logic [N_W-1:0] cnt_q, n_q, cnt_inc;
  logic           run_q, hi_q, wrap;

  always_comb begin
    cnt_inc = cnt_q + N_W'(1);
    wrap    = (cnt_q == n_q - N_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      n_q   <= N_W'(1);
      run_q <= 1'b0;
      hi_q  <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      n_q   <= ratio;
      run_q <= 1'b0;
      hi_q  <= 1'b0;
    end else if (!run_q || wrap) begin
      cnt_q <= '0;
      n_q   <= ratio;
      run_q <= 1'b1;
      hi_q  <= (ratio >= N_W'(2));
    end else begin
      cnt_q <= cnt_inc;
      hi_q  <= (cnt_inc < (n_q >> 1));
    end
  end

  assign run   = run_q;
  assign hi    = hi_q;
  assign cnt   = cnt_q;
  assign cur_n = n_q;
endmodule

// File: rtl/cascade_clkdiv.sv
module cascade_clkdiv #(
  parameter int M_W   = 3,
  parameter int P_W   = 2,
  parameter int M_OFF = 1,
  parameter int P_OFF = 1
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic [M_W+P_W-1:0] cfg_word,
  input  logic               lin_mode,
  input  logic               en,
  output logic               clk_out
);
  localparam int MD_W = $clog2((1 << M_W) + M_OFF);
  localparam int PL_W = $clog2((1 << P_W) + P_OFF);
  localparam int PS_W = (1 << P_W);
  localparam int PD_W = (PS_W > PL_W) ? PS_W : PL_W;
  localparam int N_W  = MD_W + PD_W;

  logic [N_W-1:0] ratio_w, cnt_w, ratio_q_w;
  logic           run_w, hi_w, bypass;

  cdiv_ratio #(
    .M_W(M_W), .P_W(P_W), .M_OFF(M_OFF), .P_OFF(P_OFF),
    .MD_W(MD_W), .PD_W(PD_W), .N_W(N_W)
  ) u_ratio (
    .cfg_word(cfg_word),
    .lin_mode(lin_mode),
    .ratio   (ratio_w)
  );

  cdiv_phase #(.N_W(N_W)) u_phase (
    .clk  (clk_in),
    .rst_n(rst_n),
    .en   (en),
    .ratio(ratio_w),
    .run  (run_w),
    .hi   (hi_w),
    .cnt  (cnt_w),
    .cur_n(ratio_q_w)
  );

  always_comb begin
    bypass  = run_w && en && (ratio_q_w == N_W'(1));
    clk_out = bypass ? clk_in : hi_w;
  end
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
  parameter int N_W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           run,
  input logic           hi,
  input logic [N_W-1:0] cnt,
  input logic [N_W-1:0] cur_n
);
  a_r8_off_empties: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!run && !hi));

  a_r1_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < cur_n));

  a_r6_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0) |-> $stable(cur_n));

  a_r5_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi) |-> (cnt == '0));

  a_r5_fall_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $fell(hi)) |-> (cnt == (cur_n >> 1)));
endmodule

bind cascade_clkdiv cdiv_checker #(.N_W(N_W)) u_chk (
  .clk  (clk_in),
  .rst_n(rst_n),
  .en   (en),
  .run  (run_w),
  .hi   (hi_w),
  .cnt  (cnt_w),
  .cur_n(ratio_q_w)
);

// File: tb/cascade_clkdiv_tb.sv
module cascade_clkdiv_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cfg_word = '0;
  logic       lin_mode = 1'b0;
  logic       en = 1'b0;
  logic       clk_out;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R9";

  // behavioural reference state
  int  r_pos = 0;
  int  r_len = 1;
  bit  r_on  = 0;

  always #4 clk = ~clk;

  cascade_clkdiv u_dut (
    .clk_in(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .lin_mode(lin_mode), .en(en), .clk_out(clk_out)
  );

  function automatic int want_ratio(logic [4:0] c, logic lin);
    int m = int'(c[2:0]) + 1;
    int p = lin ? int'(c[4:3]) + 1 : (1 << c[4:3]);
    return m * p;
  endfunction

  function automatic bit want_level(bit phase_hi);
    if (!r_on) return 1'b0;
    if (r_len == 1) return phase_hi;
    return (r_pos < r_len / 2);
  endfunction

  task automatic check(bit got, bit exp, string t);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: clk_out=%0b expected %0b at %0t", t, got, exp, $time);
    end
  endtask

  // model step at each rising edge, compare in both phases
  always @(posedge clk) begin
    if (!rst_n) begin
      r_pos = 0; r_len = 1; r_on = 0;
    end else begin
      if (!en) begin
        r_on = 0; r_pos = 0; r_len = want_ratio(cfg_word, lin_mode);
      end else if (!r_on || r_pos == r_len - 1) begin
        r_on = 1; r_pos = 0; r_len = want_ratio(cfg_word, lin_mode);
      end else begin
        r_pos++;
      end
      #2 check(clk_out, want_level(1'b1), tag);
      #4 check(clk_out, want_level(1'b0), tag);
    end
  end

  task automatic shape(input logic [2:0] m, input logic [1:0] p,
                       input logic lin, input string t);
    int n = (int'(m) + 1) * (lin ? int'(p) + 1 : (1 << p));
    int hcount = 0;
    int expect_h = (n == 1) ? 2 : 2 * (n / 2);
    @(negedge clk);
    en = 1'b0;
    tag = t;
    cfg_word = {p, m};
    lin_mode = lin;
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < 2 * n; i++) begin
      @(posedge clk);
      #2;
      if (clk_out) hcount++;
    end
    n_chk++;
    if (hcount != expect_h) begin
      n_bad++;
      $display("FAIL %s: high samples=%0d expected %0d (N=%0d)", t, hcount, expect_h, n);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R9: reset holds the output low
    repeat (3) @(negedge clk);
    check(clk_out, 1'b0, "R9 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(clk_out, 1'b0, "R8 idle after reset");

    shape(3'd0, 2'd0, 1'b0, "R7 ratio one");
    shape(3'd2, 2'd0, 1'b0, "R2 R5 odd N=3");
    shape(3'd3, 2'd1, 1'b0, "R3 exp N=8");
    shape(3'd7, 2'd3, 1'b0, "R1 R3 max N=64");
    shape(3'd1, 2'd2, 1'b1, "R4 lin N=6");
    shape(3'd4, 2'd3, 1'b1, "R4 lin N=20");
    shape(3'd0, 2'd3, 1'b1, "R4 lin N=4");
    shape(3'd6, 2'd0, 1'b1, "R5 odd N=7");

    // R6: rewrite mid-period, then let the model follow for a while
    shape(3'd7, 2'd1, 1'b0, "R6 base N=16");
    tag = "R6 mid-period change";
    repeat (3) @(negedge clk);
    cfg_word = {2'd0, 3'd1};
    lin_mode = 1'b1;
    repeat (40) @(negedge clk);

    // R8: disable during a running high phase
    tag = "R8 disable";
    cfg_word = {2'd2, 3'd3};
    lin_mode = 1'b0;
    repeat (20) @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    #2 check(clk_out, 1'b0, "R8 low after disable");
    repeat (5) @(negedge clk);
    en = 1'b1;
    @(posedge clk);
    #2 check(clk_out, 1'b1, "R8 period starts high");
    repeat (40) @(negedge clk);

    // R7: pass-through toggles between phases
    tag = "R7 pass-through";
    cfg_word = '0;
    repeat (40) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule